// File: doc/BRIEF.md
# Dual-Clock Audio Sample FIFO with DMA Request Levels

This block sits between a host bus and a serial audio shifter. It holds one FIFO of 32-bit words for each direction. The host pushes playback words and pops capture words through a single shared data address. The shifter consumes playback words and produces capture words in its own serial clock domain. Fill levels cross between the domains as Gray-coded pointers. Control bits cross through two-flop synchronizers.

Each direction drives two DMA request lines. One is a normal request and one is an urgent (panic) request, each compared against its own programmable level. A playback request asks for more data while the FIFO is at or below its level. A capture request asks for draining while the FIFO is above its level.

Flushing a FIFO is carried out by the serial domain. A readback loop through the serial domain lets software confirm that the slow side has caught up. A wake bit is delayed through the serial domain before the shifter is told it may run.

Top module: `audio_fifo_dreq`

## Requirements
- R1: After reset, the control/status word (address 0) reads 0x00000300, which means playback empty (bit 8) and playback has room (bit 9). The level word (address 2) reads 0x10303020. All four request outputs are low.
- R2: A write to address 1 appends a word to the playback FIFO. Each `tx_pop` taken while `tx_run` is high advances to the next word, and `tx_word` presents the words in write order. A write while the FIFO holds DEPTH words is dropped.
- R3: A read of address 1 returns the oldest capture word and removes it. Capture words enter on `rx_push` while `rx_run` is high. Bit 10 of the status word reports that capture data is present, and bit 11 reports a full capture FIFO.
- R4: The level word holds four 7-bit levels: playback panic in [30:24], capture panic in [22:16], playback request in [14:8] and capture request in [6:0]. `tx_dreq` is high when the playback fill is at or below the playback request level, and `tx_panic` is high when the fill is at or below the playback panic level.
- R5: `rx_dreq` is high when the capture fill is strictly above the capture request level. `rx_panic` is high when the capture fill is strictly above the capture panic level.
- R6: All four request outputs stay low while the DMA enable bit (bit 4) is clear.
- R7: Playback-on (bit 0) and capture-on (bit 1) reach the serial side as `tx_run` and `rx_run`. A `tx_pop` while `tx_run` is low consumes nothing. An `rx_push` while `rx_run` is low stores nothing.
- R8: A `tx_pop` on an empty playback FIFO while running sets the sticky underflow flag (bit 12). Only a control write with bit 12 set clears it.
- R9: An `rx_push` into a full capture FIFO drops the word and sets the sticky overflow flag (bit 13). Only a control write with bit 13 set clears it.
- R10: Writing 1 to bit 2 (playback) or bit 3 (capture) flushes that FIFO through the serial domain. The bit reads 1 until the serial side has acknowledged the flush. A flush leaves the error flags unchanged.
- R11: Bit 5 reads back the written value only after it has passed through the serial domain and back again, so the readback right after a write still shows the old value.
- R12: The wake bit (bit 6) raises `port_awake` after four serial clock stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops capture at address 1) |
| reg_addr | input | 2 | 0 control/status, 1 data, 2 levels |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational |
| tx_dreq | output | 1 | Playback normal request |
| tx_panic | output | 1 | Playback urgent request |
| rx_dreq | output | 1 | Capture normal request |
| rx_panic | output | 1 | Capture urgent request |
| sclk | input | 1 | Serial clock |
| tx_pop | input | 1 | Shifter takes the head playback word |
| tx_word | output | 32 | Head playback word |
| tx_run | output | 1 | Playback enable, serial domain |
| rx_push | input | 1 | Shifter delivers a capture word |
| rx_word | input | 32 | Capture word |
| rx_run | output | 1 | Capture enable, serial domain |
| port_awake | output | 1 | Wake bit after serial-domain delay |

## Verification
The request logic is tested with fills that step through each level one word at a time. This separates "at or below" from "below" for playback, and "above" from "at or above" for capture. The normal and panic levels are set to different values, so a swapped comparison shows up.

Both FIFOs are filled past DEPTH. A dropped word is then told apart from an overwritten one by the exact order of the drained data. Pops and pushes with the direction switched off show that the gating leaves the FIFO untouched. Flushes are issued while an error flag is set, which separates emptying the FIFO from resetting the flag.

// File: rtl/audio_fifo_dreq.sv
module audio_fifo_dreq #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_dreq,
  output logic        tx_panic,
  output logic        rx_dreq,
  output logic        rx_panic,
  input  logic        sclk,
  input  logic        tx_pop,
  output logic [31:0] tx_word,
  output logic        tx_run,
  input  logic        rx_push,
  input  logic [31:0] rx_word,
  output logic        rx_run,
  output logic        port_awake
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];

  // host domain state
  logic          tx_on_q, rx_on_q, txclr_req, rxclr_req, dma_en, sync_req, wake_q;
  logic          tx_uf, rx_of;
  logic [6:0]    lvl_txp, lvl_rxp, lvl_txr, lvl_rxr;
  logic [PW-1:0] tx_wp, tx_wg, tx_rg_m, tx_rg_s;
  logic [PW-1:0] rx_rp, rx_rg, rx_wg_m, rx_wg_s;
  logic [4:0]    bk_m, bk_s;
  logic [1:0]    ev_p;

  // serial domain state
  logic [5:0]    ctl_m, ctl_s;
  logic [1:0]    wake_d;
  logic [PW-1:0] tx_rp, tx_rg, tx_wg_sm, tx_wg_ss;
  logic [PW-1:0] rx_wp, rx_wg, rx_rg_sm, rx_rg_ss;
  logic          uf_tg, of_tg;

  logic [PW-1:0] tx_fill, rx_fill;
  logic          wr_ctl, wr_dat, wr_lvl, rd_dat, tx_acc, rx_take;
  logic          tx_s_empty, rx_s_full, rx_store;
  logic          unused_bits;

  assign wr_ctl  = reg_wr && reg_addr == 2'd0;
  assign wr_dat  = reg_wr && reg_addr == 2'd1;
  assign wr_lvl  = reg_wr && reg_addr == 2'd2;
  assign rd_dat  = reg_rd && reg_addr == 2'd1;
  assign tx_fill = tx_wp - g2b(tx_rg_s);
  assign rx_fill = g2b(rx_wg_s) - rx_rp;
  assign tx_acc  = wr_dat && tx_fill != FULLV;
  assign rx_take = rd_dat && rx_fill != '0;
  assign unused_bits = ^{reg_wdata[31], reg_wdata[23], reg_wdata[15:14],
                         reg_wdata[11:7]};

  assign tx_dreq  = dma_en && (32'(tx_fill) <= 32'(lvl_txr));
  assign tx_panic = dma_en && (32'(tx_fill) <= 32'(lvl_txp));
  assign rx_dreq  = dma_en && (32'(rx_fill) >  32'(lvl_rxr));
  assign rx_panic = dma_en && (32'(rx_fill) >  32'(lvl_rxp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tx_on_q, rx_on_q, txclr_req, rxclr_req, dma_en, sync_req, wake_q} <= '0;
      {tx_uf, rx_of} <= '0;
      lvl_txp <= 7'h10; lvl_rxp <= 7'h30; lvl_txr <= 7'h30; lvl_rxr <= 7'h20;
      tx_wp <= '0; tx_wg <= '0; tx_rg_m <= '0; tx_rg_s <= '0;
      rx_rp <= '0; rx_rg <= '0; rx_wg_m <= '0; rx_wg_s <= '0;
      bk_m <= '0; bk_s <= '0; ev_p <= '0;
    end else begin
      if (wr_ctl) begin
        tx_on_q  <= reg_wdata[0];
        rx_on_q  <= reg_wdata[1];
        dma_en   <= reg_wdata[4];
        sync_req <= reg_wdata[5];
        wake_q   <= reg_wdata[6];
      end
      if (txclr_req && bk_s[0]) txclr_req <= 1'b0;
      else if (wr_ctl && reg_wdata[2] && !bk_s[0]) txclr_req <= 1'b1;
      if (rxclr_req && bk_s[1]) rxclr_req <= 1'b0;
      else if (wr_ctl && reg_wdata[3] && !bk_s[1]) rxclr_req <= 1'b1;

      if (bk_s[3] != ev_p[0]) tx_uf <= 1'b1;
      else if (wr_ctl && reg_wdata[12]) tx_uf <= 1'b0;
      if (bk_s[4] != ev_p[1]) rx_of <= 1'b1;
      else if (wr_ctl && reg_wdata[13]) rx_of <= 1'b0;

      if (wr_lvl) begin
        lvl_txp <= reg_wdata[30:24];
        lvl_rxp <= reg_wdata[22:16];
        lvl_txr <= reg_wdata[14:8];
        lvl_rxr <= reg_wdata[6:0];
      end

      if (tx_acc) tx_wp <= tx_wp + 1'b1;
      if (rxclr_req && bk_s[1]) rx_rp <= g2b(rx_wg_s);
      else if (rx_take) rx_rp <= rx_rp + 1'b1;

      tx_wg   <= b2g(tx_wp);
      rx_rg   <= b2g(rx_rp);
      tx_rg_m <= tx_rg;  tx_rg_s <= tx_rg_m;
      rx_wg_m <= rx_wg;  rx_wg_s <= rx_wg_m;
      bk_m    <= {of_tg, uf_tg, ctl_s[4:2]};
      bk_s    <= bk_m;
      ev_p    <= bk_s[4:3];
    end
  end

  always_ff @(posedge clk)
    if (tx_acc) tx_mem[tx_wp[AW-1:0]] <= reg_wdata;

  assign tx_s_empty = tx_rp == g2b(tx_wg_ss);
  assign rx_s_full  = (rx_wp - g2b(rx_rg_ss)) == FULLV;
  assign rx_store   = rx_push && ctl_s[1] && !ctl_s[3] && !rx_s_full;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_m <= '0; ctl_s <= '0; wake_d <= '0;
      tx_rp <= '0; tx_rg <= '0; tx_wg_sm <= '0; tx_wg_ss <= '0;
      rx_wp <= '0; rx_wg <= '0; rx_rg_sm <= '0; rx_rg_ss <= '0;
      uf_tg <= 1'b0; of_tg <= 1'b0;
    end else begin
      ctl_m    <= {wake_q, sync_req, rxclr_req, txclr_req, rx_on_q, tx_on_q};
      ctl_s    <= ctl_m;
      wake_d   <= {wake_d[0], ctl_s[5]};
      tx_wg_sm <= tx_wg;  tx_wg_ss <= tx_wg_sm;
      rx_rg_sm <= rx_rg;  rx_rg_ss <= rx_rg_sm;

      if (ctl_s[2]) tx_rp <= g2b(tx_wg_ss);
      else if (tx_pop && ctl_s[0]) begin
        if (tx_s_empty) uf_tg <= ~uf_tg;
        else tx_rp <= tx_rp + 1'b1;
      end

      if (rx_push && ctl_s[1] && !ctl_s[3] && rx_s_full) of_tg <= ~of_tg;
      if (rx_store) rx_wp <= rx_wp + 1'b1;

      tx_rg <= b2g(tx_rp);
      rx_wg <= b2g(rx_wp);
    end
  end

  always_ff @(posedge sclk)
    if (rx_store) rx_mem[rx_wp[AW-1:0]] <= rx_word;

  assign tx_word    = tx_mem[tx_rp[AW-1:0]];
  assign tx_run     = ctl_s[0];
  assign rx_run     = ctl_s[1];
  assign port_awake = wake_d[1];

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = {18'b0, rx_of, tx_uf, rx_fill == FULLV, rx_fill != '0,
                         tx_fill != FULLV, tx_fill == '0, 1'b0, wake_q, bk_s[2],
                         dma_en, rxclr_req, txclr_req, rx_on_q, tx_on_q};
      2'd1: reg_rdata = rx_mem[rx_rp[AW-1:0]];
      2'd2: reg_rdata = {1'b0, lvl_txp, 1'b0, lvl_rxp, 1'b0, lvl_txr, 1'b0, lvl_rxr};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_fifo_dreq_chk.sv
module audio_fifo_dreq_chk #(
  parameter int DEPTH = 64,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          dma_en,
  input logic          tx_dreq,
  input logic          tx_panic,
  input logic          rx_dreq,
  input logic          rx_panic,
  input logic [PW-1:0] tx_fill,
  input logic [PW-1:0] rx_fill,
  input logic [PW-1:0] tx_wp,
  input logic [PW-1:0] rx_rp,
  input logic          rxclr_req,
  input logic          tx_uf,
  input logic          rx_of
);
  assert_dma_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !(tx_dreq || tx_panic || rx_dreq || rx_panic));

  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fill <= PW'(DEPTH));

  assert_rx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fill <= PW'(DEPTH));

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && tx_fill == PW'(DEPTH)) |=> $stable(tx_wp));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1 && rx_fill == '0 && !rxclr_req) |=> $stable(rx_rp));

  assert_uf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_uf && !(reg_wr && reg_addr == 2'd0 && reg_wdata[12])) |=> tx_uf);

  assert_of_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_of && !(reg_wr && reg_addr == 2'd0 && reg_wdata[13])) |=> rx_of);
endmodule

bind audio_fifo_dreq audio_fifo_dreq_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .dma_en(dma_en),
  .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic),
  .tx_fill(tx_fill), .rx_fill(rx_fill), .tx_wp(tx_wp), .rx_rp(rx_rp),
  .rxclr_req(rxclr_req), .tx_uf(tx_uf), .rx_of(rx_of)
);

// File: tb/tb_audio_fifo_dreq.sv
module tb_audio_fifo_dreq;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_PERIOD = 26;
  localparam int DEPTH = 64;

  logic clk = 0, sclk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_dreq, tx_panic, rx_dreq, rx_panic;
  logic tx_pop = 0, rx_push = 0;
  logic [31:0] tx_word, rx_word = 0;
  logic tx_run, rx_run, port_awake;

  int n_tests = 0, n_fail = 0;
  bit mon_on = 0;
  logic [31:0] tx_exp[$];
  logic [31:0] rx_exp[$];
  logic [31:0] v, e;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SCLK_PERIOD/2) sclk = ~sclk;

  audio_fifo_dreq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic),
    .sclk(sclk), .tx_pop(tx_pop), .tx_word(tx_word), .tx_run(tx_run),
    .rx_push(rx_push), .rx_word(rx_word), .rx_run(rx_run), .port_awake(port_awake));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic push_tx(input logic [31:0] w, input bit keep);
    hw(2'd1, w);
    if (keep) tx_exp.push_back(w);
  endtask

  task automatic pop_tx(input int n);
    @(negedge sclk); tx_pop = 1;
    repeat (n) @(negedge sclk);
    tx_pop = 0;
  endtask

  task automatic push_rx(input logic [31:0] w, input bit keep);
    @(negedge sclk); rx_push = 1; rx_word = w;
    @(negedge sclk); rx_push = 0;
    if (keep) rx_exp.push_back(w);
  endtask

  task automatic ws(input int n);
    repeat (n) @(negedge sclk);
  endtask

  // scoreboard monitor: compares each consumed playback word
  always @(negedge sclk) begin
    #2;
    if (mon_on && tx_pop) begin
      if (tx_exp.size() == 0) chk("R2 unexpected tx pop", tx_word, 32'hx);
      else begin
        e = tx_exp.pop_front();
        chk("R2 tx order", tx_word, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #103 rst_n = 1;
    // R1 reset state
    hr(2'd0, v); chk("R1 status", v, 32'h0000_0300);
    hr(2'd2, v); chk("R1 levels", v, 32'h1030_3020);
    chk("R1 requests", {28'b0, tx_dreq, tx_panic, rx_dreq, rx_panic}, 32'h0);

    // R6 gating then enable
    hw(2'd0, 32'h10);
    chk("R6 tx requests on", {30'b0, tx_dreq, tx_panic}, 32'h3);
    chk("R6 rx requests idle", {30'b0, rx_dreq, rx_panic}, 32'h0);
    hw(2'd0, 32'h11); ws(4);
    chk("R7 tx_run follows", {31'b0, tx_run}, 32'h1);

    // R4 levels: tx panic 2, rx panic 3, tx req 4, rx req 1
    hw(2'd2, 32'h0203_0401);
    push_tx(32'hA000_0001, 1); push_tx(32'hA000_0002, 1);
    chk("R4 panic at level", {31'b0, tx_panic}, 32'h1);
    push_tx(32'hA000_0003, 1);
    chk("R4 panic above level", {31'b0, tx_panic}, 32'h0);
    push_tx(32'hA000_0004, 1);
    chk("R4 dreq at level", {31'b0, tx_dreq}, 32'h1);
    push_tx(32'hA000_0005, 1);
    chk("R4 dreq above level", {31'b0, tx_dreq}, 32'h0);

    // R2 ordered drain
    ws(6); mon_on = 1; pop_tx(5); mon_on = 0; ws(6);
    hr(2'd0, v); chk("R2 tx empty after drain", {31'b0, v[8]}, 32'h1);
    chk("R4 dreq after drain", {31'b0, tx_dreq}, 32'h1);

    // R7 pops ignored while off
    hw(2'd0, 32'h10); ws(4);
    chk("R7 tx_run off", {31'b0, tx_run}, 32'h0);
    push_tx(32'h0000_A5A5, 1); ws(6);
    pop_tx(3); ws(6);
    hr(2'd0, v);
    chk("R7 word kept while off", {31'b0, v[8]}, 32'h0);
    chk("R7 no underflow while off", {31'b0, v[12]}, 32'h0);
    hw(2'd0, 32'h11); ws(4);
    mon_on = 1; pop_tx(1); mon_on = 0;

    // R8 underflow sticky, W1C
    pop_tx(1); ws(6);
    hr(2'd0, v); chk("R8 underflow set", {31'b0, v[12]}, 32'h1);
    hw(2'd0, 32'h11);
    hr(2'd0, v); chk("R8 stays without W1C", {31'b0, v[12]}, 32'h1);
    hw(2'd0, 32'h1011);
    hr(2'd0, v); chk("R8 cleared by W1C", {31'b0, v[12]}, 32'h0);

    // R2 full: extra word dropped
    ws(4);
    for (int i = 0; i <= DEPTH; i++) push_tx(32'hB000_0000 + i, i < DEPTH);
    hr(2'd0, v); chk("R2 no room when full", {31'b0, v[9]}, 32'h0);
    ws(6); mon_on = 1; pop_tx(DEPTH); mon_on = 0; ws(6);
    chk("R2 all words drained", tx_exp.size(), 32'h0);
    hr(2'd0, v); chk("R2 empty after full drain", {31'b0, v[8]}, 32'h1);

    // R3/R5 capture path and levels
    hw(2'd0, 32'h13); ws(4);
    chk("R7 rx_run follows", {31'b0, rx_run}, 32'h1);
    push_rx(32'hC000_0001, 1); ws(2);
    hr(2'd0, v); chk("R3 rx has data", {31'b0, v[10]}, 32'h1);
    chk("R5 rx dreq at level", {31'b0, rx_dreq}, 32'h0);
    push_rx(32'hC000_0002, 1); ws(2);
    chk("R5 rx dreq above level", {31'b0, rx_dreq}, 32'h1);
    push_rx(32'hC000_0003, 1); ws(2);
    chk("R5 rx panic at level", {31'b0, rx_panic}, 32'h0);
    push_rx(32'hC000_0004, 1); ws(2);
    chk("R5 rx panic above level", {31'b0, rx_panic}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      hr(2'd1, v); e = rx_exp.pop_front(); chk("R3 rx order", v, e);
    end
    hr(2'd0, v); chk("R3 rx drained", {31'b0, v[10]}, 32'h0);
    chk("R5 rx dreq drained", {31'b0, rx_dreq}, 32'h0);

    // R7 pushes ignored while off
    hw(2'd0, 32'h11); ws(4);
    chk("R7 rx_run off", {31'b0, rx_run}, 32'h0);
    push_rx(32'hDEAD_0001, 0); push_rx(32'hDEAD_0002, 0); ws(6);
    hr(2'd0, v); chk("R7 rx push ignored", {31'b0, v[10]}, 32'h0);

    // R9 overflow
    hw(2'd0, 32'h13); ws(4);
    for (int i = 0; i <= DEPTH; i++) push_rx(32'hE000_0000 + i, i < DEPTH);
    ws(6);
    hr(2'd0, v);
    chk("R3 rx full flag", {31'b0, v[11]}, 32'h1);
    chk("R9 overflow set", {31'b0, v[13]}, 32'h1);
    for (int i = 0; i < 2; i++) begin
      hr(2'd1, v); e = rx_exp.pop_front(); chk("R9 kept order", v, e);
    end

    // R10 capture flush keeps error
    hw(2'd0, 32'h1B);
    hr(2'd0, v); chk("R10 rx flush pending", {31'b0, v[3]}, 32'h1);
    ws(10);
    hr(2'd0, v);
    chk("R10 rx flush done", {31'b0, v[3]}, 32'h0);
    chk("R10 rx emptied", {31'b0, v[10]}, 32'h0);
    chk("R10 overflow kept", {31'b0, v[13]}, 32'h1);
    rx_exp.delete();
    hw(2'd0, 32'h2013);
    hr(2'd0, v); chk("R9 overflow W1C", {31'b0, v[13]}, 32'h0);

    // R10 playback flush
    hw(2'd0, 32'h12);
    push_tx(32'hF000_0001, 0); push_tx(32'hF000_0002, 0); push_tx(32'hF000_0003, 0);
    hr(2'd0, v); chk("R10 tx not empty before flush", {31'b0, v[8]}, 32'h0);
    ws(6);
    hw(2'd0, 32'h16);
    hr(2'd0, v); chk("R10 tx flush pending", {31'b0, v[2]}, 32'h1);
    ws(10);
    hr(2'd0, v);
    chk("R10 tx flush done", {31'b0, v[2]}, 32'h0);
    chk("R10 tx emptied", {31'b0, v[8]}, 32'h1);
    chk("R10 underflow untouched", {31'b0, v[12]}, 32'h0);

    // R11 sync round trip
    hw(2'd0, 32'h32);
    hr(2'd0, v); chk("R11 sync not yet back", {31'b0, v[5]}, 32'h0);
    ws(6);
    hr(2'd0, v); chk("R11 sync returned", {31'b0, v[5]}, 32'h1);
    hw(2'd0, 32'h12);
    hr(2'd0, v); chk("R11 sync old value held", {31'b0, v[5]}, 32'h1);
    ws(6);
    hr(2'd0, v); chk("R11 sync cleared", {31'b0, v[5]}, 32'h0);

    // R12 wake
    hw(2'd0, 32'h52);
    chk("R12 awake not immediate", {31'b0, port_awake}, 32'h0);
    ws(8);
    chk("R12 awake after delay", {31'b0, port_awake}, 32'h1);

    finish_up();
  end
endmodule